// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block is the digital front end of an 8-bit current-steering converter. On each rising clock edge it takes a straight-binary input word and turns it into switch controls for a unit-source array. The array has two unary segments. The five upper bits set a 31-line thermometer vector that drives equal coarse units. The three lower bits set a 7-line thermometer vector that drives fine units. Each fine unit is worth one eighth of a coarse unit. A steering line that is high sends its source to the true output; a line that is low sends it to the complementary output.

An active-high sleep input turns every source off. It does this through a separate pair of enable vectors, which go low from the next edge. While sleep is held, the steering vectors keep their last values and new input words are not taken in. For checking the transfer function, the block also gives a behavioural weight for each output side. Each weight counts the coarse units on that side at eight and the fine units at one.

Top module: `sdac_switch_decoder`

## Requirements
- R1: The input word is registered on the rising clock edge. The steering vectors and weights show a new word only after the first rising edge at which it is present with sleep low, which gives one cycle of latency.
- R2: Bits 7..3 of the input form the coarse value V. Coarse steering line i (0..30) is high exactly when V > i, so the vector fills from index 0 upward.
- R3: Bits 2..0 of the input form the fine value L. Fine steering line i (0..6) is high exactly when L > i.
- R4: The true-side weight equals 8 × (coarse lines high) + (fine lines high), and this equals the registered code.
- R5: The complementary weight equals 255 minus the registered code. Code 255 drives every steering line high, so the complementary weight is 0. Code 0 drives every steering line low, so the true weight is 0.
- R6: If sleep is high at a rising edge, every coarse and fine enable line is 0 after that edge. If sleep is low at a rising edge, every enable line is 1 after it.
- R7: While sleep is high, the input word is ignored and the steering vectors and weights hold their values. The first edge with sleep low captures the word present at that edge.
- R8: A synchronous active-high reset sets the registered code to 0, so all steering lines are low. It also sets all enable lines high, and it takes priority over sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Straight-binary input code, bit 7 most significant |
| sleep | input | 1 | Active-high power-down; tie low when unused |
| hi_steer | output | 31 | Coarse-unit steering thermometer, 1 = true output |
| lo_steer | output | 7 | Fine-unit steering thermometer, 1 = true output |
| hi_enable | output | 31 | Coarse-unit source enables, all 0 in sleep |
| lo_enable | output | 7 | Fine-unit source enables, all 0 in sleep |
| weight_true | output | 11 | Behavioural weight of units steered to the true output |
| weight_comp | output | 11 | Behavioural weight of units steered to the complementary output |

## Verification
The hardest case to reach from the ports is the sleep interval: the input word changes, yet the steering state must stay frozen. This matters most on the edge where sleep is released, because the word present at that edge must be captured and nothing earlier. The stimulus changes the input several times while sleep is held. It checks the held weights and the zero enables, then drops sleep and compares the very next cycle. A sweep of all 256 codes covers every thermometer fill, including both ends. A random phase mixes sleep and reset pulses and checks the reset-over-sleep priority against a cycle model.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int CODE_W_DEF = 8;
    localparam int HI_W_DEF   = 5;
    localparam int WT_W_DEF   = 11;

    typedef enum logic {
        PWR_ON    = 1'b0,
        PWR_SLEEP = 1'b1
    } pwr_e;

    function automatic int unsigned units_of(input int unsigned bits);
        return (32'd1 << bits) - 32'd1;
    endfunction

endpackage

// File: rtl/sdac_therm_dec.sv
module sdac_therm_dec #(
    parameter int VAL_W = 5,
    localparam int N    = (1 << VAL_W) - 1
) (
    input  logic [VAL_W-1:0] val,
    output logic [N-1:0]     line
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            assign line[i] = (val > VAL_W'(i));
        end
    endgenerate

endmodule

// File: rtl/sdac_steer_reg.sv
module sdac_steer_reg #(
    parameter int HI_N = 31,
    parameter int LO_N = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [HI_N-1:0] hi_d,
    input  logic [LO_N-1:0] lo_d,
    output logic [HI_N-1:0] hi_q,
    output logic [LO_N-1:0] lo_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    AST_HI_THERM: assert property (@(posedge clk) disable iff (rst)
        ((hi_q & (hi_q + HI_N'(1))) == '0));                          // R2
    AST_LO_THERM: assert property (@(posedge clk) disable iff (rst)
        ((lo_q & (lo_q + LO_N'(1))) == '0));                          // R3
    AST_HOLD_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(hi_q) && $stable(lo_q)));                  // R7

endmodule

// File: rtl/sdac_enable_ctl.sv
module sdac_enable_ctl
    import sdac_pkg::*;
#(
    parameter int HI_N = 31,
    parameter int LO_N = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep,
    output logic [HI_N-1:0] hi_en,
    output logic [LO_N-1:0] lo_en
);

    pwr_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_ON;
        end else begin
            state <= sleep ? PWR_SLEEP : PWR_ON;
        end
    end

    assign hi_en = (state == PWR_ON) ? '1 : '0;
    assign lo_en = (state == PWR_ON) ? '1 : '0;

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ((hi_en == '0) && (lo_en == '0)));                  // R6
    AST_AWAKE_ON: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> ((&hi_en) && (&lo_en)));                           // R6

endmodule

// File: rtl/sdac_weigher.sv
module sdac_weigher #(
    parameter int HI_N = 31,
    parameter int LO_N = 7,
    parameter int LO_W = 3,
    parameter int WT_W = 11
) (
    input  logic [HI_N-1:0] hi_line,
    input  logic [LO_N-1:0] lo_line,
    output logic [WT_W-1:0] w_true,
    output logic [WT_W-1:0] w_comp
);

    logic [WT_W-1:0] hi_on, lo_on, hi_off, lo_off;

    always_comb begin
        hi_on  = '0;
        hi_off = '0;
        for (int i = 0; i < HI_N; i++) begin
            hi_on  = hi_on  + WT_W'(hi_line[i]);
            hi_off = hi_off + WT_W'(!hi_line[i]);
        end
    end

    always_comb begin
        lo_on  = '0;
        lo_off = '0;
        for (int i = 0; i < LO_N; i++) begin
            lo_on  = lo_on  + WT_W'(lo_line[i]);
            lo_off = lo_off + WT_W'(!lo_line[i]);
        end
    end

    assign w_true = (hi_on  << LO_W) + lo_on;
    assign w_comp = (hi_off << LO_W) + lo_off;

endmodule

// File: rtl/sdac_switch_decoder.sv
module sdac_switch_decoder
    import sdac_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int HI_W   = HI_W_DEF,
    parameter int WT_W   = WT_W_DEF,
    localparam int LO_W  = CODE_W - HI_W,
    localparam int HI_N  = (1 << HI_W) - 1,
    localparam int LO_N  = (1 << LO_W) - 1,
    localparam int FULL  = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        din,
    input  logic              sleep,
    output logic [30:0]       hi_steer,
    output logic [6:0]        lo_steer,
    output logic [30:0]       hi_enable,
    output logic [6:0]        lo_enable,
    output logic [10:0]       weight_true,
    output logic [10:0]       weight_comp
);

    logic [HI_N-1:0] hi_dec;
    logic [LO_N-1:0] lo_dec;

    sdac_therm_dec #(.VAL_W(HI_W)) u_hi_dec (
        .val  (din[CODE_W-1:LO_W]),
        .line (hi_dec)
    );

    sdac_therm_dec #(.VAL_W(LO_W)) u_lo_dec (
        .val  (din[LO_W-1:0]),
        .line (lo_dec)
    );

    sdac_steer_reg #(.HI_N(HI_N), .LO_N(LO_N)) u_steer (
        .clk  (clk),
        .rst  (rst),
        .load (!sleep),
        .hi_d (hi_dec),
        .lo_d (lo_dec),
        .hi_q (hi_steer),
        .lo_q (lo_steer)
    );

    sdac_enable_ctl #(.HI_N(HI_N), .LO_N(LO_N)) u_en (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .hi_en (hi_enable),
        .lo_en (lo_enable)
    );

    sdac_weigher #(.HI_N(HI_N), .LO_N(LO_N), .LO_W(LO_W), .WT_W(WT_W)) u_wt (
        .hi_line (hi_steer),
        .lo_line (lo_steer),
        .w_true  (weight_true),
        .w_comp  (weight_comp)
    );

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> (weight_true == WT_W'($past(din))));               // R1
    AST_TRUE_IS_CODE: assert property (@(posedge clk) disable iff (rst)
        (weight_true <= WT_W'(FULL)));                                // R4
    AST_SIDES_SUM: assert property (@(posedge clk) disable iff (rst)
        ((weight_true + weight_comp) == WT_W'(FULL)));                // R5

endmodule

// File: tb/tb_sdac_switch_decoder.sv
module tb_sdac_switch_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        sleep = 1'b0;
    logic [30:0] hi_steer, hi_enable;
    logic [6:0]  lo_steer, lo_enable;
    logic [10:0] weight_true, weight_comp;

    int checks = 0;
    int errors = 0;
    int m_code = 0;
    bit m_en = 1'b1;
    bit m_valid = 1'b0;
    bit done = 1'b0;

    sdac_switch_decoder dut (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .sleep       (sleep),
        .hi_steer    (hi_steer),
        .lo_steer    (lo_steer),
        .hi_enable   (hi_enable),
        .lo_enable   (lo_enable),
        .weight_true (weight_true),
        .weight_comp (weight_comp)
    );

    always #10 clk = ~clk;

    // Cycle model of the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_code <= 0;
            m_en   <= 1'b1;
        end else begin
            m_en <= !sleep;
            if (!sleep) m_code <= int'(din);
        end
        m_valid <= 1'b1;
    end

    function automatic logic [30:0] exp_hi(input int v);
        logic [30:0] r;
        for (int i = 0; i < 31; i++) r[i] = ((v / 8) > i);
        return r;
    endfunction

    function automatic logic [6:0] exp_lo(input int v);
        logic [6:0] r;
        for (int i = 0; i < 7; i++) r[i] = ((v % 8) > i);
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R2", "coarse steering", 64'(hi_steer), 64'(exp_hi(m_code)));
            chk("R3", "fine steering", 64'(lo_steer), 64'(exp_lo(m_code)));
            chk("R4", "true weight", 64'(weight_true), 64'(m_code));
            chk("R5", "complementary weight", 64'(weight_comp), 64'(255 - m_code));
            chk("R6", "coarse enables", 64'(hi_enable), m_en ? 64'h7FFF_FFFF : 64'h0);
            chk("R6", "fine enables", 64'(lo_enable), m_en ? 64'h7F : 64'h0);
        end
    end

    initial begin
        din = 8'hA5;
        sleep = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", "steering after reset", 64'({hi_steer, lo_steer}), 64'h0);
        chk("R8", "enables after reset", 64'({hi_enable, lo_enable}), {26'h0, 38'h3F_FFFF_FFFF});
        sleep = 1'b0;
        rst = 1'b0;

        for (int c = 0; c < 256; c++) begin
            din = 8'(c);
            @(negedge clk);
        end
        chk("R5", "code 255 coarse all true", 64'(hi_steer), 64'h7FFF_FFFF);
        chk("R5", "code 255 complementary zero", 64'(weight_comp), 64'h0);

        din = 8'h3C;
        #1;
        chk("R1", "no change before edge", 64'(weight_true), 64'd255);
        @(negedge clk);
        chk("R1", "new code after edge", 64'(weight_true), 64'h3C);

        din = 8'h81;
        @(negedge clk);
        sleep = 1'b1;
        din = 8'h7E;
        @(negedge clk);
        chk("R6", "sleep turns enables off", 64'({hi_enable, lo_enable}), 64'h0);
        chk("R7", "input ignored in sleep", 64'(weight_true), 64'h81);
        din = 8'h12;
        repeat (3) @(negedge clk);
        chk("R7", "steering held in sleep", 64'(weight_true), 64'h81);
        sleep = 1'b0;
        #1;
        chk("R6", "enables off until edge", 64'(hi_enable), 64'h0);
        @(negedge clk);
        chk("R7", "capture on sleep release", 64'(weight_true), 64'h12);
        chk("R6", "enables back on", 64'(lo_enable), 64'h7F);

        din = 8'h00;
        @(negedge clk);
        chk("R5", "code 0 true weight zero", 64'(weight_true), 64'h0);

        sleep = 1'b1;
        rst = 1'b1;
        din = 8'hFF;
        @(negedge clk);
        chk("R8", "reset beats sleep", 64'(hi_enable), 64'h7FFF_FFFF);
        rst = 1'b0;
        sleep = 1'b0;

        repeat (300) begin
            din   = 8'($urandom);
            sleep = (($urandom % 5) == 0);
            rst   = (($urandom % 40) == 0);
            @(negedge clk);
        end
        rst = 1'b0;
        sleep = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule